// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block counts clock cycles up to a selectable limit. What happens at the limit depends on the mode. In watchdog mode, each expiry sets a status flag and sends a one-cycle request to the chip's reset generator. In interval mode, each expiry sets the same flag and raises an interrupt line, provided the interrupt enable is high. Software must keep writing the control word before the limit is reached. Every control write carries a key byte in its upper half. A write with the wrong key is refused, and it is treated the same way as a watchdog expiry.

The flag records why the last reset happened, so a reset that this block requested does not clear it. Only a power-on reset or an event on the external reset pin clears the flag. A system reset returns the control word and the count to their defaults and leaves the flag as it was.

Top module: `wdog_itimer`

## Requirements
- R1: After `rst`, `wdt_flag`, `int_req` and `reset_req` are low. The block starts in watchdog mode with the longest interval (2^15 cycles), not held, with the count at zero.
- R2: A write whose bits [15:8] differ from 0x5A is refused. On the next clock `wdt_flag` is high and `reset_req` pulses high for one cycle. The control word keeps its previous value.
- R3: A keyed write loads bits [1:0] as the interval select: 0 gives 2^15 cycles, 1 gives 2^13, 2 gives 2^9 and 3 gives 2^6. Bit 3 selects the mode: 0 is watchdog, 1 is interval. Bit 4 is hold. Bit 2 is clear.
- R4: In watchdog mode, when a run of 2^k cycles completes without a clear, the flag is set and `reset_req` pulses for one cycle.
- R5: In interval mode, the flag is set at every completed interval and `reset_req` stays low. The count then starts over at zero.
- R6: `int_req` is high only while the flag is set, `int_en` is high and the mode is interval. `int_en` has no effect in watchdog mode.
- R7: While hold is set, the count does not advance and no expiry occurs.
- R8: A keyed write with bit 2 set returns the count to zero. Clear is not stored, so a later write without bit 2 leaves the count running.
- R9: In interval mode, `int_ack` clears the flag on the next clock. If an expiry happens in the same cycle, the flag stays set. In watchdog mode, `int_ack` is ignored.
- R10: `rst` and `pin_rst_evt` clear the flag. `sys_rst` restores the control word and the count to their defaults but keeps the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_evt | input | 1 | Reset pin event, clears everything including the flag |
| sys_rst | input | 1 | System reset, clears control and count, keeps the flag |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 16 | Control write data: key in [15:8], fields in [4:0] |
| int_en | input | 1 | Interrupt enable, used only in interval mode |
| int_ack | input | 1 | Interrupt acknowledge |
| wdt_flag | output | 1 | Expiry or key-fault flag |
| int_req | output | 1 | Interval interrupt request |
| reset_req | output | 1 | One-cycle request to the system reset generator |

## Verification
The hardest case to reach from the ports is an interval expiry that lands in the same cycle as an acknowledge. The bench gets there by issuing a clearing write and then counting exactly 63 edges at the shortest interval, so that `int_ack` is sampled on the edge where the count hits its limit. Two more cases need timed stimulus. One is a wrong-key write while in interval mode; a steady 64-cycle interrupt period afterwards shows that the refused write changed nothing. The other is a run of clears spaced just under the interval, which must hold off every expiry. A behavioural model checks the three outputs on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CFG_W    = 16;
    localparam int KEY_W    = 8;
    localparam int SEL_W    = 2;
    localparam int NSEL     = 1 << SEL_W;
    localparam logic [KEY_W-1:0] KEY_VAL = 8'h5A;

    localparam int BIT_CLR  = 2;
    localparam int BIT_MODE = 3;
    localparam int BIT_HOLD = 4;

    typedef enum logic {
        MODE_WATCHDOG = 1'b0,
        MODE_INTERVAL = 1'b1
    } tmode_e;

    typedef struct packed {
        logic             hold;
        tmode_e           mode;
        logic [SEL_W-1:0] sel;
    } tctrl_t;

    typedef struct packed {
        logic   valid;
        logic   key_ok;
        logic   clr;
        tctrl_t ctrl;
    } twrite_t;

    localparam tctrl_t CTRL_RESET = '{hold: 1'b0, mode: MODE_WATCHDOG, sel: '0};

    function automatic twrite_t decode_write(input logic en, input logic [CFG_W-1:0] d);
        twrite_t w;
        w.valid     = en;
        w.key_ok    = (d[CFG_W-1 -: KEY_W] == KEY_VAL);
        w.clr       = d[BIT_CLR];
        w.ctrl.sel  = d[SEL_W-1:0];
        w.ctrl.mode = tmode_e'(d[BIT_MODE]);
        w.ctrl.hold = d[BIT_HOLD];
        return w;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             ctl_rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output tctrl_t           ctrl,
    output logic             clr_now,
    output logic             key_fault
);

    twrite_t wr;
    tctrl_t  ctrl_q;

    always_comb wr = decode_write(cfg_we, cfg_wdata);

    always_ff @(posedge clk) begin
        if (ctl_rst)
            ctrl_q <= CTRL_RESET;
        else if (wr.valid && wr.key_ok)
            ctrl_q <= wr.ctrl;
    end

    assign ctrl      = ctrl_q;
    assign clr_now   = wr.valid && wr.key_ok && wr.clr;
    assign key_fault = wr.valid && !wr.key_ok;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int S0    = 15,
    parameter int S1    = 13,
    parameter int S2    = 9,
    parameter int S3    = 6,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             cnt_rst,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr_now,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam int SH_TAB [NSEL] = '{S0, S1, S2, S3};

    logic [CNT_W-1:0] lim_tab [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        localparam int SH = SH_TAB[g];
        assign lim_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
    end

    assign lim    = lim_tab[sel];
    assign expire = !hold && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (cnt_rst)
            cnt_q <= '0;
        else if (clr_now)
            cnt_q <= '0;
        else if (expire)
            cnt_q <= '0;
        else if (!hold)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdog_flag.sv
module wdog_flag
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   flag_clr,
    input  logic   sys_rst,
    input  logic   expire,
    input  logic   key_fault,
    input  tmode_e mode,
    input  logic   int_en,
    input  logic   int_ack,
    output logic   flag,
    output logic   int_req,
    output logic   reset_req
);

    logic flag_q;
    logic req_q;
    logic is_itv;

    assign is_itv = (mode == MODE_INTERVAL);

    always_ff @(posedge clk) begin
        if (flag_clr)
            flag_q <= 1'b0;
        else if (sys_rst)
            flag_q <= flag_q;
        else if (expire || key_fault)
            flag_q <= 1'b1;
        else if (int_ack && is_itv)
            flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (flag_clr || sys_rst)
            req_q <= 1'b0;
        else
            req_q <= (expire && !is_itv) || key_fault;
    end

    assign flag      = flag_q;
    assign reset_req = req_q;
    assign int_req   = flag_q && int_en && is_itv;

endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
    import wdog_pkg::*;
#(
    parameter int SHIFT_LONG  = 15,
    parameter int SHIFT_MID   = 13,
    parameter int SHIFT_SHORT = 9,
    parameter int SHIFT_TINY  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_rst_evt,
    input  logic             sys_rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             int_en,
    input  logic             int_ack,
    output logic             wdt_flag,
    output logic             int_req,
    output logic             reset_req
);

    localparam int CNT_W = max4(SHIFT_LONG, SHIFT_MID, SHIFT_SHORT, SHIFT_TINY);

    tctrl_t           ctrl_w;
    logic             clr_w;
    logic             fault_w;
    logic [CNT_W-1:0] cnt_w;
    logic             expire_w;
    logic             hard_rst;
    logic             any_rst;

    assign hard_rst = rst || pin_rst_evt;
    assign any_rst  = hard_rst || sys_rst;

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .ctl_rst   (any_rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl_w),
        .clr_now   (clr_w),
        .key_fault (fault_w)
    );

    wdog_counter #(
        .S0    (SHIFT_LONG),
        .S1    (SHIFT_MID),
        .S2    (SHIFT_SHORT),
        .S3    (SHIFT_TINY),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .cnt_rst (any_rst),
        .hold    (ctrl_w.hold),
        .sel     (ctrl_w.sel),
        .clr_now (clr_w),
        .cnt     (cnt_w),
        .expire  (expire_w)
    );

    wdog_flag u_flag (
        .clk       (clk),
        .flag_clr  (hard_rst),
        .sys_rst   (sys_rst),
        .expire    (expire_w),
        .key_fault (fault_w),
        .mode      (ctrl_w.mode),
        .int_en    (int_en),
        .int_ack   (int_ack),
        .flag      (wdt_flag),
        .int_req   (int_req),
        .reset_req (reset_req)
    );

endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             pin_rst_evt,
    input logic             sys_rst,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             int_en,
    input logic             int_ack,
    input logic             wdt_flag,
    input logic             int_req,
    input logic             reset_req,
    input tctrl_t           ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic             expire
);

    logic bad_wr;
    logic good_wr;
    assign bad_wr  = cfg_we && (cfg_wdata[CFG_W-1 -: KEY_W] != KEY_VAL);
    assign good_wr = cfg_we && !bad_wr;

    p_key_fault_r2: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        bad_wr |=> (wdt_flag && reset_req && $stable(ctrl)));

    p_wd_expire_r4: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        (expire && ctrl.mode == MODE_WATCHDOG) |=> (wdt_flag && reset_req));

    p_itv_expire_r5: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        (expire && ctrl.mode == MODE_INTERVAL && !bad_wr) |=> (wdt_flag && !reset_req));

    p_irq_wd_r6: assert property (@(posedge clk) disable iff (rst || pin_rst_evt)
        (ctrl.mode == MODE_WATCHDOG || !wdt_flag || !int_en) |-> !int_req);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        (ctrl.hold && !cfg_we) |=> $stable(cnt));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        (good_wr && cfg_wdata[BIT_CLR]) |=> (cnt == '0));

    p_ack_r9: assert property (@(posedge clk) disable iff (rst || pin_rst_evt || sys_rst)
        (int_ack && ctrl.mode == MODE_INTERVAL && !expire && !bad_wr) |=> !wdt_flag);

    p_sys_keep_r10: assert property (@(posedge clk) disable iff (rst || pin_rst_evt)
        (sys_rst && wdt_flag) |=> wdt_flag);

endmodule

bind wdog_itimer wdog_itimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_rst_evt (pin_rst_evt),
    .sys_rst     (sys_rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .int_en      (int_en),
    .int_ack     (int_ack),
    .wdt_flag    (wdt_flag),
    .int_req     (int_req),
    .reset_req   (reset_req),
    .ctrl        (ctrl_w),
    .cnt         (cnt_w),
    .expire      (expire_w)
);

// File: tb/wdog_itimer_test.sv
module wdog_itimer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_rst_evt = 1'b0;
    logic        sys_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = 16'h0;
    logic        int_en = 1'b0;
    logic        int_ack = 1'b0;
    logic        wdt_flag;
    logic        int_req;
    logic        reset_req;

    always #4 clk = ~clk;

    wdog_itimer uut (
        .clk         (clk),
        .rst         (rst),
        .pin_rst_evt (pin_rst_evt),
        .sys_rst     (sys_rst),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .int_en      (int_en),
        .int_ack     (int_ack),
        .wdt_flag    (wdt_flag),
        .int_req     (int_req),
        .reset_req   (reset_req)
    );

    int    checks = 0;
    int    failures = 0;
    string phase = "R1";
    bit    done = 1'b0;

    int m_cnt = 0, m_sel = 0, m_mode = 0, m_hold = 0, m_flag = 0, m_req = 0;

    function automatic int m_len(input int s);
        case (s)
            0:       return 1 << 15;
            1:       return 1 << 13;
            2:       return 1 << 9;
            default: return 1 << 6;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, one step per clock
    always @(posedge clk) begin : model_step
        bit ex, bad, ok;
        if (rst || pin_rst_evt) begin
            m_cnt = 0; m_sel = 0; m_mode = 0; m_hold = 0; m_flag = 0; m_req = 0;
        end else if (sys_rst) begin
            m_cnt = 0; m_sel = 0; m_mode = 0; m_hold = 0; m_req = 0;
        end else begin
            ex  = (m_hold == 0) && (m_cnt >= m_len(m_sel) - 1);
            bad = cfg_we && (cfg_wdata[15:8] != 8'h5A);
            ok  = cfg_we && !bad;
            m_req = ((ex && m_mode == 0) || bad) ? 1 : 0;
            if (ex || bad) m_flag = 1;
            else if (int_ack && m_mode == 1) m_flag = 0;
            if (ok && cfg_wdata[2]) m_cnt = 0;
            else if (m_hold != 0) m_cnt = m_cnt;
            else if (ex) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (ok) begin
                m_sel  = int'(cfg_wdata[1:0]);
                m_mode = int'(cfg_wdata[3]);
                m_hold = int'(cfg_wdata[4]);
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        int exp_irq;
        if (!done) begin
            exp_irq = (m_flag == 1 && int_en && m_mode == 1) ? 1 : 0;
            chk(phase, "flag", int'(wdt_flag), m_flag);
            chk(phase, "reset_req", int'(reset_req), m_req);
            chk(phase, "int_req", int'(int_req), exp_irq);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        cyc(1);
        cfg_we = 1'b0;
        cfg_wdata = 16'h0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        cyc(1);
        int_ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin : stimulus
        cyc(3);
        rst = 1'b0;

        // R1 reset state
        phase = "R1";
        chk("R1", "flag", int'(wdt_flag), 0);
        chk("R1", "reset_req", int'(reset_req), 0);
        chk("R1", "int_req", int'(int_req), 0);

        // R4 default long interval in watchdog mode, R6 enable ignored
        phase = "R4";
        int_en = 1'b1;
        cyc(32767);
        chk("R4", "flag before expiry", int'(wdt_flag), 0);
        cyc(1);
        chk("R4", "flag at expiry", int'(wdt_flag), 1);
        chk("R4", "reset_req at expiry", int'(reset_req), 1);
        chk("R6", "int_req in watchdog mode", int'(int_req), 0);
        cyc(1);
        chk("R4", "reset_req single pulse", int'(reset_req), 0);

        // R10 system reset keeps flag, pin reset clears it
        phase = "R10";
        sys_rst = 1'b1; cyc(1); sys_rst = 1'b0;
        chk("R10", "flag kept over sys_rst", int'(wdt_flag), 1);
        pin_rst_evt = 1'b1; cyc(1); pin_rst_evt = 1'b0;
        chk("R10", "flag cleared by pin reset", int'(wdt_flag), 0);

        // R5 interval mode, shortest interval, interrupt gating
        phase = "R5";
        int_en = 1'b0;
        wr(16'h5A0F);
        cyc(63);
        chk("R5", "flag before interval end", int'(wdt_flag), 0);
        cyc(1);
        chk("R5", "flag at interval end", int'(wdt_flag), 1);
        chk("R5", "no reset_req in interval mode", int'(reset_req), 0);
        chk("R6", "int_req with enable low", int'(int_req), 0);
        int_en = 1'b1;
        #1;
        chk("R6", "int_req with enable high", int'(int_req), 1);
        phase = "R9";
        ack();
        chk("R9", "ack clears flag", int'(wdt_flag), 0);

        // R2 wrong key refused, control unchanged
        phase = "R2";
        wr(16'h1200);
        chk("R2", "flag after bad key", int'(wdt_flag), 1);
        chk("R2", "reset_req after bad key", int'(reset_req), 1);
        cyc(1);
        chk("R2", "reset_req pulse ends", int'(reset_req), 0);
        ack();
        chk("R2", "still interval mode so ack clears", int'(wdt_flag), 0);
        cyc(150);

        // R7 hold freezes counting
        phase = "R7";
        wr(16'h5A1F);
        ack();
        cyc(200);
        chk("R7", "no expiry while held", int'(wdt_flag), 0);

        // R8 clear not stored
        phase = "R8";
        wr(16'h5A0B);
        for (int i = 0; i < 5; i++) begin
            cyc(40);
            wr(16'h5A0F);
        end
        chk("R8", "periodic clears stop expiry", int'(wdt_flag), 0);
        cyc(63);
        chk("R8", "no expiry just before limit", int'(wdt_flag), 0);
        cyc(1);
        chk("R8", "expiry once clears stop", int'(wdt_flag), 1);

        // R6 and R9 in watchdog mode
        phase = "R6";
        ack();
        wr(16'h5A07);
        cyc(64);
        chk("R4", "short watchdog expiry", int'(wdt_flag), 1);
        chk("R6", "int_req stays low in watchdog mode", int'(int_req), 0);
        ack();
        chk("R9", "ack ignored in watchdog mode", int'(wdt_flag), 1);

        // R9 expiry wins over ack in the same cycle
        phase = "R9";
        wr(16'h5A0F);
        ack();
        cyc(62);
        int_ack = 1'b1;
        cyc(1);
        int_ack = 1'b0;
        chk("R9", "flag set when expiry meets ack", int'(wdt_flag), 1);

        // R3 other interval selections
        phase = "R3";
        ack();
        wr(16'h5A0E);
        cyc(511);
        chk("R3", "sel2 before limit", int'(wdt_flag), 0);
        cyc(1);
        chk("R3", "sel2 expiry at 2^9", int'(wdt_flag), 1);
        ack();
        wr(16'h5A0D);
        cyc(8191);
        chk("R3", "sel1 before limit", int'(wdt_flag), 0);
        cyc(1);
        chk("R3", "sel1 expiry at 2^13", int'(wdt_flag), 1);
        cyc(3);

        finish_run();
    end

endmodule